// File: doc/BRIEF.md
# PCI Target Burst Address Tracker

This block is the target-side front end for a 32-bit PCI-style bus on which address and data share the AD lines. It watches each address phase and records the command issued on C/BE#. It sorts the cycle into one of four classes: I/O, memory, configuration or special. The block claims a memory cycle only when the dword address falls inside a window set by a base and a size. Each target does its own decoding, so no external select is used.

Once the block claims a cycle, it answers with fast DEVSEL# and TRDY#. It then turns each completed data phase into a single-cycle local read or write strobe, with an address and byte enables. The target advances the dword address by itself after every completed phase. Only linear-incrementing bursts are accepted. Any other ordering code, or a burst that would run past the end of the window, ends with a disconnect after the phase in progress.

Top module: `pbt_burst_target`

## Requirements
- R1: `cyc_class` is updated in the clock after each address phase. Its encoding is 1 = I/O (commands 0010, 0011), 2 = memory (0110, 0111, 1100, 1110, 1111), 3 = configuration (1010, 1011), 4 = special (0000, 0001) and 0 = reserved (0100, 0101, 1000, 1001, 1101).
- R2: The block claims a cycle when the command is a memory command and AD[31:2] satisfies `win_base <= AD[31:2] < win_base + win_size`. In the clock after the address phase it then drives `devsel_n` and `trdy_n` low. In every other case `devsel_n` stays high for the whole transaction.
- R3: A data phase completes only in a clock where `irdy_n` and `trdy_n` are both low. In that clock exactly one strobe is high: `lcl_wr` for commands 0111 and 1111, otherwise `lcl_rd`. In the same clock, `lcl_be` equals `~cbe_n` and `lcl_wdata` equals `ad_in`.
- R4: During the first data phase, `lcl_addr` holds the AD[31:2] value captured in the address phase. It increases by one after each completed phase. A clock with `irdy_n` high leaves it unchanged.
- R5: While a claimed read is in its data state, `ad_oe` is high and `ad_out` equals `lcl_rdata`.
- R6: If AD[1:0] is not 00 in a claimed address phase, the first data phase completes. In the next clock `stop_n` goes low and `trdy_n` goes high.
- R7: A phase may complete while `frame_n` is still low. If the next dword would lie outside the window, the block disconnects in the same way as in R6.
- R8: A completed phase with `frame_n` high releases `devsel_n`, `trdy_n` and `stop_n` (all high) in the next clock. After a disconnect, a clock with `frame_n` high and `irdy_n` low releases them in the same way.
- R9: After reset `devsel_n`, `trdy_n` and `stop_n` are high, both strobes and `ad_oe` are low, and `cyc_class` is 0.
- R10: An unclaimed transaction produces no local strobe. The block waits for `frame_n` and `irdy_n` to be high together before it accepts a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_in | input | 32 | Multiplexed address/data from the master |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| frame_n | input | 1 | Transaction in progress, active low |
| irdy_n | input | 1 | Master ready, active low |
| win_base | input | 30 | First dword of the claimed window |
| win_size | input | 30 | Window length in dwords |
| lcl_rdata | input | 32 | Read data from local storage at `lcl_addr` |
| devsel_n | output | 1 | Target claims the cycle, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |
| ad_out | output | 32 | Read data onto the bus |
| ad_oe | output | 1 | Enable for `ad_out` |
| cyc_class | output | 3 | Class of the latest address phase |
| lcl_addr | output | 30 | Current dword address |
| lcl_wr | output | 1 | Local write strobe |
| lcl_rd | output | 1 | Local read strobe |
| lcl_be | output | 4 | Local byte enables, active high |
| lcl_wdata | output | 32 | Local write data |

## Verification
The assertions assume a well-behaved master. It holds the window inputs steady during a transaction and starts an address phase only on an idle bus. After seeing STOP#, it takes `frame_n` high while it keeps `irdy_n` low. The bench follows these rules by construction: all bus activity comes from one transaction task that programs the window once, returns the bus to idle between cycles, and ends disconnected bursts in exactly that order. Inside those rules the bench sweeps every command code, every dword around both edges of the window, the ordering codes and inserted master wait states.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  localparam int PBT_AW = 32;
  localparam int PBT_DA = PBT_AW - 2;
  localparam int PBT_BE = PBT_AW / 8;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_IO   = 3'd1,
    CLS_MEM  = 3'd2,
    CLS_CFG  = 3'd3,
    CLS_SPC  = 3'd4
  } pbt_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_HALT,
    ST_SKIP
  } pbt_state_e;

  function automatic pbt_class_e pbt_classify(input logic [3:0] c);
    case (c)
      4'b0000, 4'b0001:                            return CLS_SPC;
      4'b0010, 4'b0011:                            return CLS_IO;
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return CLS_MEM;
      4'b1010, 4'b1011:                            return CLS_CFG;
      default:                                     return CLS_NONE;
    endcase
  endfunction

  // Unsigned offset compare: wraps cleanly and a zero size never hits.
  function automatic logic pbt_in_win(input logic [PBT_DA-1:0] a,
                                      input logic [PBT_DA-1:0] base,
                                      input logic [PBT_DA-1:0] size);
    return (a - base) < size;
  endfunction

  function automatic logic [PBT_DA-1:0] pbt_step(input logic [PBT_DA-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/pbt_cmd_decode.sv
module pbt_cmd_decode
  import pbt_pkg::*;
(
  input  logic [3:0]  cmd,
  output pbt_class_e  cls,
  output logic        is_mem,
  output logic        is_wr
);
  always_comb begin
    cls    = pbt_classify(cmd);
    is_mem = (cls == CLS_MEM);
    is_wr  = cmd[0];
  end
endmodule

// File: rtl/pbt_win_cmp.sv
module pbt_win_cmp
  import pbt_pkg::*;
#(
  parameter int W = PBT_DA
) (
  input  logic [W-1:0] probe,
  input  logic [W-1:0] base,
  input  logic [W-1:0] size,
  output logic         hit
);
  assign hit = pbt_in_win(probe, base, size);
endmodule

// File: rtl/pbt_addr_ctr.sv
module pbt_addr_ctr
  import pbt_pkg::*;
#(
  parameter int W = PBT_DA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= pbt_step(q);
  end
endmodule

// File: rtl/pbt_burst_target.sv
module pbt_burst_target
  import pbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PBT_AW-1:0] ad_in,
  input  logic [3:0]        cbe_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [PBT_DA-1:0] win_base,
  input  logic [PBT_DA-1:0] win_size,
  input  logic [PBT_AW-1:0] lcl_rdata,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic [PBT_AW-1:0] ad_out,
  output logic              ad_oe,
  output logic [2:0]        cyc_class,
  output logic [PBT_DA-1:0] lcl_addr,
  output logic              lcl_wr,
  output logic              lcl_rd,
  output logic [PBT_BE-1:0] lcl_be,
  output logic [PBT_AW-1:0] lcl_wdata
);
  localparam int NCMP = 2;

  pbt_state_e state_q;
  pbt_class_e cls_q, dec_cls;
  logic       dec_mem, dec_wr;
  logic       wr_q, lin_q;
  logic       dsel_q, trdy_q, stop_q;

  // Named internal events, also used by the bound checker
  logic addr_phase, claim, xfer, last_xfer, cut, halt_done, skip_done;

  logic [NCMP-1:0]   win_hit;
  logic [PBT_DA-1:0] win_probe [NCMP];

  pbt_cmd_decode u_dec (
    .cmd    (cbe_n),
    .cls    (dec_cls),
    .is_mem (dec_mem),
    .is_wr  (dec_wr)
  );

  // Probe 0: address on the bus; probe 1: dword after the current one
  assign win_probe[0] = ad_in[PBT_AW-1:2];
  assign win_probe[1] = pbt_step(lcl_addr);

  for (genvar g = 0; g < NCMP; g++) begin : g_win
    pbt_win_cmp #(.W(PBT_DA)) u_cmp (
      .probe (win_probe[g]),
      .base  (win_base),
      .size  (win_size),
      .hit   (win_hit[g])
    );
  end

  assign addr_phase = (state_q == ST_IDLE) && !frame_n;
  assign claim      = addr_phase && dec_mem && win_hit[0];
  assign xfer       = (state_q == ST_DATA) && !irdy_n && trdy_q;
  assign last_xfer  = xfer && frame_n;
  assign cut        = xfer && !frame_n && (!lin_q || !win_hit[1]);
  assign halt_done  = (state_q == ST_HALT) && frame_n && !irdy_n;
  assign skip_done  = (state_q == ST_SKIP) && frame_n && irdy_n;

  pbt_addr_ctr #(.W(PBT_DA)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (claim),
    .load_val (win_probe[0]),
    .step     (xfer),
    .q        (lcl_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cls_q   <= CLS_NONE;
      wr_q    <= 1'b0;
      lin_q   <= 1'b0;
    end else begin
      if (addr_phase) begin
        cls_q <= dec_cls;
        wr_q  <= dec_wr;
        lin_q <= (ad_in[1:0] == 2'b00);
      end
      unique case (state_q)
        ST_IDLE: if (addr_phase) state_q <= claim ? ST_DATA : ST_SKIP;
        ST_DATA: begin
          if (last_xfer) state_q <= ST_IDLE;
          else if (cut)  state_q <= ST_HALT;
        end
        ST_HALT: if (halt_done) state_q <= ST_IDLE;
        ST_SKIP: if (skip_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsel_q <= 1'b0;
      trdy_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (claim)                       dsel_q <= 1'b1;
      else if (last_xfer || halt_done) dsel_q <= 1'b0;
      if (claim)                       trdy_q <= 1'b1;
      else if (last_xfer || cut)       trdy_q <= 1'b0;
      if (cut)                         stop_q <= 1'b1;
      else if (halt_done)              stop_q <= 1'b0;
    end
  end

  assign devsel_n  = !dsel_q;
  assign trdy_n    = !trdy_q;
  assign stop_n    = !stop_q;
  assign cyc_class = cls_q;
  assign lcl_wr    = xfer && wr_q;
  assign lcl_rd    = xfer && !wr_q;
  assign lcl_be    = ~cbe_n;
  assign lcl_wdata = ad_in;
  assign ad_oe     = (state_q == ST_DATA) && !wr_q;
  assign ad_out    = lcl_rdata;
endmodule

// File: rtl/pbt_checker.sv
module pbt_checker
  import pbt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n,
  input logic              irdy_n,
  input logic              devsel_n,
  input logic              trdy_n,
  input logic              stop_n,
  input logic              lcl_wr,
  input logic              lcl_rd,
  input logic [PBT_DA-1:0] lcl_addr,
  input logic              addr_phase,
  input logic              claim,
  input logic              xfer,
  input logic              cut
);
  // R2
  claim_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (!devsel_n && !trdy_n));

  // R2
  no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !claim) |=> devsel_n);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lcl_wr, lcl_rd}));

  // R3
  strobe_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_wr || lcl_rd) |-> (!irdy_n && !trdy_n && !devsel_n));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !frame_n) |=> (lcl_addr == $past(lcl_addr) + 1'b1));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && irdy_n) |=> $stable(lcl_addr));

  // R6
  cut_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut |=> (!stop_n && trdy_n));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_n) |=> (devsel_n && trdy_n && stop_n));

  // R2
  trdy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
endmodule

bind pbt_burst_target pbt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .devsel_n   (devsel_n),
  .trdy_n     (trdy_n),
  .stop_n     (stop_n),
  .lcl_wr     (lcl_wr),
  .lcl_rd     (lcl_rd),
  .lcl_addr   (lcl_addr),
  .addr_phase (addr_phase),
  .claim      (claim),
  .xfer       (xfer),
  .cut        (cut)
);

// File: tb/sim_pbt_burst_target.sv
`timescale 1ns/1ps
module sim_pbt_burst_target;
  localparam logic [29:0] BASE = 30'h100;
  localparam logic [29:0] SIZE = 30'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1, irdy_n = 1'b1;
  logic [31:0] lcl_rdata;
  logic        devsel_n, trdy_n, stop_n, ad_oe, lcl_wr, lcl_rd;
  logic [31:0] ad_out, lcl_wdata;
  logic [2:0]  cyc_class;
  logic [29:0] lcl_addr;
  logic [3:0]  lcl_be;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [31:0] bmem [16];

  always #2.5 clk = ~clk;

  pbt_burst_target u0 (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n(cbe_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .win_base(BASE), .win_size(SIZE), .lcl_rdata(lcl_rdata),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .cyc_class(cyc_class), .lcl_addr(lcl_addr), .lcl_wr(lcl_wr),
    .lcl_rd(lcl_rd), .lcl_be(lcl_be), .lcl_wdata(lcl_wdata)
  );

  // Bench-side local storage: 16 dwords indexed by the low address bits
  assign lcl_rdata = bmem[lcl_addr[3:0]];
  always @(posedge clk) begin
    if (lcl_wr) begin
      for (int b = 0; b < 4; b++)
        if (lcl_be[b]) bmem[lcl_addr[3:0]][8*b +: 8] <= lcl_wdata[8*b +: 8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_class(input logic [3:0] c);
    if (c[3:1] == 3'b000) return 4;
    if (c[3:1] == 3'b001) return 1;
    if (c[3:1] == 3'b101) return 3;
    if (c == 4'd6 || c == 4'd7 || c == 4'd12 || c == 4'd14 || c == 4'd15) return 2;
    return 0;
  endfunction

  function automatic bit in_win(input longint dw);
    return (dw >= longint'(BASE)) && (dw < longint'(BASE) + longint'(SIZE));
  endfunction

  // One transaction; wait_at < 0 means no master wait state
  task automatic run_txn(input logic [3:0] cmd, input logic [31:0] baddr,
                         input int n, input logic [3:0] be, input int wait_at);
    logic [29:0] dw;
    bit claimed, wr, stopped;
    int lim, nexp, done;
    dw = baddr[31:2];
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = baddr; cbe_n = cmd;
    @(negedge clk); #1;
    claimed = (exp_class(cmd) == 2) && in_win(longint'(dw));
    wr = cmd[0];
    chk(cyc_class == 3'(exp_class(cmd)), "R1 class", 32'(cyc_class), 32'(exp_class(cmd)));
    chk(devsel_n == !claimed, "R2 devsel", 32'(devsel_n), 32'(!claimed));
    chk(trdy_n == !claimed, "R2 trdy", 32'(trdy_n), 32'(!claimed));
    if (!claimed) begin
      frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hDEAD_0000;
      #1 chk(!lcl_wr && !lcl_rd, "R10 no strobe", 32'({lcl_wr, lcl_rd}), 0);
      @(negedge clk); irdy_n = 1'b1;
      #1 chk(devsel_n && trdy_n, "R10 stays idle", 32'({devsel_n, trdy_n}), 3);
      return;
    end
    lim = (baddr[1:0] != 2'b00) ? 1 : int'(longint'(BASE) + longint'(SIZE) - longint'(dw));
    nexp = (n < lim) ? n : lim;
    done = 0; stopped = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k == wait_at) begin
        irdy_n = 1'b1; frame_n = 1'b0;
        #1 chk(!lcl_wr && !lcl_rd, "R3 wait no strobe", 32'({lcl_wr, lcl_rd}), 0);
        chk(lcl_addr == dw + 30'(k), "R4 hold on wait", 32'(lcl_addr), 32'(dw + 30'(k)));
        @(negedge clk);
      end
      irdy_n = 1'b0; frame_n = (k == n - 1);
      ad_in = wr ? (32'h5A00_0000 | 32'(dw + 30'(k))) : 32'h0;
      cbe_n = ~be;
      #1;
      if (!stop_n) begin
        chk(done == nexp, "R6/R7 phases before stop", 32'(done), 32'(nexp));
        chk(trdy_n, "R6 trdy off in stop", 32'(trdy_n), 1);
        frame_n = 1'b1;
        @(negedge clk); irdy_n = 1'b1;
        #1 chk(devsel_n && trdy_n && stop_n, "R8 release after stop",
               32'({devsel_n, trdy_n, stop_n}), 7);
        stopped = 1'b1;
        break;
      end
      chk(!trdy_n, "R3 trdy", 32'(trdy_n), 0);
      chk(lcl_addr == dw + 30'(k), "R4 addr", 32'(lcl_addr), 32'(dw + 30'(k)));
      chk(lcl_wr == wr && lcl_rd == !wr, "R3 strobe", 32'({lcl_wr, lcl_rd}), 32'({wr, !wr}));
      chk(lcl_be == be, "R3 be", 32'(lcl_be), 32'(be));
      if (wr) chk(lcl_wdata == ad_in, "R3 wdata", lcl_wdata, ad_in);
      else begin
        chk(ad_oe, "R5 oe", 32'(ad_oe), 1);
        chk(ad_out == bmem[4'(dw + 30'(k))], "R5 rdata", ad_out, bmem[4'(dw + 30'(k))]);
      end
      done++;
      @(negedge clk);
    end
    if (!stopped) begin
      chk(done == nexp, "R7 phase count", 32'(done), 32'(nexp));
      irdy_n = 1'b1; frame_n = 1'b1;
      #1 chk(devsel_n && trdy_n && stop_n, "R8 release", 32'({devsel_n, trdy_n, stop_n}), 7);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101);
    #12;
    @(negedge clk); #1;
    // R9 reset state
    chk(devsel_n && trdy_n && stop_n, "R9 handshakes", 32'({devsel_n, trdy_n, stop_n}), 7);
    chk(!lcl_wr && !lcl_rd && !ad_oe, "R9 strobes", 32'({lcl_wr, lcl_rd, ad_oe}), 0);
    chk(cyc_class == 3'd0, "R9 class", 32'(cyc_class), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R2 all command codes at an in-window address
    for (int c = 0; c < 16; c++) run_txn(4'(c), {BASE + 30'd3, 2'b00}, 1, 4'hF, -1);
    // R2 window edges
    for (int a = -2; a < int'(SIZE) + 2; a++)
      run_txn(4'b0110, {BASE + 30'(a), 2'b00}, 1, 4'hF, -1);
    // R3/R5 write burst with partial byte enables, then read back
    run_txn(4'b0111, {BASE + 30'd1, 2'b00}, 4, 4'b0101, -1);
    run_txn(4'b1100, {BASE + 30'd1, 2'b00}, 4, 4'hF, -1);
    // R4 burst with a master wait state
    run_txn(4'b1111, {BASE, 2'b00}, 5, 4'hF, 2);
    run_txn(4'b1110, {BASE, 2'b00}, 5, 4'hF, 3);
    // R6 non-linear ordering codes
    run_txn(4'b0111, {BASE + 30'd2, 2'b10}, 3, 4'hF, -1);
    run_txn(4'b0110, {BASE + 30'd2, 2'b01}, 3, 4'hF, -1);
    run_txn(4'b0110, {BASE + 30'd2, 2'b11}, 1, 4'hF, -1);
    // R7 burst running off the window end, and exactly to it
    run_txn(4'b0111, {BASE + 30'd6, 2'b00}, 4, 4'hF, -1);
    run_txn(4'b0110, {BASE + 30'd7, 2'b00}, 1, 4'hF, -1);
    run_txn(4'b0110, {BASE + 30'd5, 2'b00}, 3, 4'hF, -1);
    // R10 unclaimed followed at once by a claimed cycle
    run_txn(4'b0011, {BASE, 2'b00}, 1, 4'hF, -1);
    run_txn(4'b0111, {BASE + 30'd4, 2'b00}, 2, 4'hF, -1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule